// File: doc/BRIEF.md
# Run-Time Tunable CIC Low-Pass Chain

This block is a streaming low-pass filter for a sampled converter stream. The bandwidth is not set by coefficients. It is set by the rate change of a four-stage cascaded integrator-comb (CIC) decimator. The decimated stream passes through a short symmetric FIR that lifts the droop the CIC leaves near the band edge. A matched four-stage CIC interpolator then brings the stream back to the input rate. Each input sample yields exactly one output sample, so the block drops into a sample path without any change of rate.

Software picks the cut-off through a small selection input. The decimation ratio is always a power of two, so every gain normalisation is a plain arithmetic shift. A new selection is applied only at the end of a decimation period. At that moment the whole filter state is cleared, so stale partial sums from the old ratio never reach the output. The chain renormalises to the sample width after the decimator. This keeps the interpolator and the compensator far narrower than a full-precision datapath would need. A status output gives the nominal latency for the ratio that is in force.

Top module: `cutoff_cic_chain`

## Requirements
- R1: Every `in_valid` pulse produces one `out_valid` pulse on the clock cycle right after it, and on no other cycle. `in_valid` pulses are at least 4 clock cycles apart.
- R2: A selection value s gives a decimation ratio R = 2^(s+1) with the default parameters, so R is 2, 4, 8 or 16. `lat_o` reports (N+3)*R+N with N=4, which is 7*R+4: 18, 32, 60 or 116.
- R3: A change of `cut_sel` does not act at once. It acts on the `in_valid` pulse that completes the current decimation period, which is the R-th pulse under the old ratio counted from reset or from the last switch. `lat_o` shows the new value from the following cycle.
- R4: The switching sample is discarded. All integrators, combs, FIR history and the output register are cleared, so that sample's output is 0, and it stays 0 for as long as the input is 0.
- R5: With a constant input x, after settling, the output equals x exactly for every ratio, with both positive and negative values. The compensator taps are (-1,3,-8,76,-8,3,-1)/64, which gives unity gain at DC.
- R6: An input that alternates +A, -A on successive samples gives an output of exactly 0 after settling, at every ratio.
- R7: After reset, `out_valid` is 0, `out_data` is 0, and the ratio is the one for selection 0 (`lat_o` = 18).
- R8: A full-scale constant input of +32767 or -32768 at the largest ratio comes back exactly. The wrap-around integrators lose no value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe marking an input sample |
| in_data | input | IN_W | Signed input sample |
| cut_sel | input | SEL_W | Cut-off selection, which picks the decimation ratio |
| out_valid | output | 1 | One-cycle strobe marking an output sample |
| out_data | output | IN_W | Signed filtered sample |
| lat_o | output | LAT_W | Nominal latency in input samples for the active ratio |

## Verification
The hardest condition to reach is a ratio switch that lands at an exactly known phase of the decimation counter. Only then can the deferral and the state clearing be observed sample by sample. The stimulus reaches it by resetting the block, so the counter starts from zero. It then counts `in_valid` pulses under the old ratio and checks `lat_o` just before and just after the boundary pulse. To expose the clearing, a long DC run first loads the interpolator integrators. The selection then changes while zeros are fed in, and any residue would show up as a non-zero output.

// File: rtl/cic_chain_pkg.sv
package cic_chain_pkg;
   localparam int COMP_TAPS  = 7;
   localparam int COMP_SHIFT = 6;

   // symmetric droop-compensation taps, sum = 2**COMP_SHIFT
   function automatic int comp_coef(input int k);
      case (k)
         0, 6:    return -1;
         1, 5:    return 3;
         2, 4:    return -8;
         default: return 76;
      endcase
   endfunction
endpackage

// File: rtl/cic_decim.sv
module cic_decim #(
   parameter int IN_W  = 16,
   parameter int N     = 4,
   parameter int L_MAX = 4,
   parameter int LW    = 3,
   parameter int AW    = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   in_valid,
   input  logic signed [IN_W-1:0] in_data,
   input  logic [LW-1:0]          log2r,
   output logic                   bound,
   output logic                   dec_stb,
   output logic signed [IN_W-1:0] dec_data
);
   localparam int CW = L_MAX;

   logic [AW-1:0] integ [N];
   logic [AW-1:0] dly   [N];
   logic [AW-1:0] cv    [N+1];
   logic [CW-1:0] cnt;
   logic [CW-1:0] rm1;

   assign rm1   = CW'((32'd1 << log2r) - 32'd1);
   assign bound = in_valid && (cnt == rm1);

   always_comb begin
      cv[0] = integ[N-1];
      for (int k = 0; k < N; k++) cv[k+1] = cv[k] - dly[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N; k++) begin
            integ[k] <= '0;
            dly[k]   <= '0;
         end
         cnt      <= '0;
         dec_stb  <= 1'b0;
         dec_data <= '0;
      end else if (clr) begin
         for (int k = 0; k < N; k++) begin
            integ[k] <= '0;
            dly[k]   <= '0;
         end
         cnt      <= '0;
         dec_stb  <= 1'b0;
         dec_data <= '0;
      end else begin
         dec_stb <= 1'b0;
         if (in_valid) begin
            integ[0] <= integ[0] + AW'(in_data);
            for (int k = 1; k < N; k++) integ[k] <= integ[k] + integ[k-1];
            cnt <= bound ? '0 : cnt + 1'b1;
         end
         if (bound) begin
            for (int k = 0; k < N; k++) dly[k] <= cv[k];
            dec_stb  <= 1'b1;
            dec_data <= IN_W'($signed(cv[N]) >>> (N * int'(log2r)));
         end
      end
   end

   // R3: the period counter never passes the active ratio
   p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= rm1);
   // R3: a decimated sample only follows an input sample
   p_dec_after_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dec_stb |-> $past(in_valid));
endmodule

// File: rtl/cic_comp_fir.sv
module cic_comp_fir
   import cic_chain_pkg::*;
#(
   parameter int W   = 16,
   parameter bit SAT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                in_stb,
   input  logic signed [W-1:0] in_data,
   output logic                out_stb,
   output logic signed [W-1:0] out_data
);
   localparam int ACW  = W + 9;
   localparam int HALF = COMP_TAPS / 2;

   logic signed [W-1:0]   hist [COMP_TAPS-1];
   logic signed [W-1:0]   win  [COMP_TAPS];
   logic signed [ACW-1:0] acc;
   logic signed [ACW-1:0] sh;
   logic signed [W-1:0]   res;

   always_comb begin
      win[0] = in_data;
      for (int k = 1; k < COMP_TAPS; k++) win[k] = hist[k-1];
      acc = ACW'(comp_coef(HALF)) * ACW'(win[HALF]);
      for (int k = 0; k < HALF; k++)
         acc = acc + ACW'(comp_coef(k)) * (ACW'(win[k]) + ACW'(win[COMP_TAPS-1-k]));
      sh = acc >>> COMP_SHIFT;
   end

   generate
      if (SAT) begin : g_sat
         localparam logic signed [ACW-1:0] HI = ACW'((2**(W-1)) - 1);
         localparam logic signed [ACW-1:0] LO = -ACW'(2**(W-1));
         always_comb begin
            if (sh > HI)      res = HI[W-1:0];
            else if (sh < LO) res = LO[W-1:0];
            else              res = W'(sh);
         end
      end else begin : g_wrap
         assign res = W'(sh);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < COMP_TAPS-1; k++) hist[k] <= '0;
         out_stb  <= 1'b0;
         out_data <= '0;
      end else if (clr) begin
         for (int k = 0; k < COMP_TAPS-1; k++) hist[k] <= '0;
         out_stb  <= 1'b0;
         out_data <= '0;
      end else begin
         out_stb <= in_stb;
         if (in_stb) begin
            hist[0] <= in_data;
            for (int k = 1; k < COMP_TAPS-1; k++) hist[k] <= hist[k-1];
            out_data <= res;
         end
      end
   end

   // R5: the compensator emits one sample per decimated sample
   p_comp_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_stb |-> $past(in_stb));
endmodule

// File: rtl/cic_interp.sv
module cic_interp #(
   parameter int IN_W = 16,
   parameter int N    = 4,
   parameter int LW   = 3,
   parameter int IW   = 29
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   in_stb,
   input  logic signed [IN_W-1:0] in_data,
   input  logic                   tick,
   input  logic [LW-1:0]          log2r,
   output logic signed [IN_W-1:0] out_data
);
   logic [IW-1:0] dly   [N];
   logic [IW-1:0] cv    [N+1];
   logic [IW-1:0] integ [N];
   logic [IW-1:0] held;
   logic          pend;

   always_comb begin
      cv[0] = IW'(in_data);
      for (int k = 0; k < N; k++) cv[k+1] = cv[k] - dly[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N; k++) begin
            dly[k]   <= '0;
            integ[k] <= '0;
         end
         held     <= '0;
         pend     <= 1'b0;
         out_data <= '0;
      end else if (clr) begin
         for (int k = 0; k < N; k++) begin
            dly[k]   <= '0;
            integ[k] <= '0;
         end
         held     <= '0;
         pend     <= 1'b0;
         out_data <= '0;
      end else begin
         if (tick) begin
            integ[0] <= integ[0] + (pend ? held : '0);
            for (int k = 1; k < N; k++) integ[k] <= integ[k] + integ[k-1];
            out_data <= IN_W'($signed(integ[N-1]) >>> ((N-1) * int'(log2r)));
            pend     <= 1'b0;
         end
         if (in_stb) begin
            for (int k = 0; k < N; k++) dly[k] <= cv[k];
            held <= cv[N];
            pend <= 1'b1;
         end
      end
   end

   // R1: a new low-rate sample never overwrites one not yet stuffed
   p_no_lost_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_stb |-> !pend);
endmodule

// File: rtl/cutoff_cic_chain.sv
module cutoff_cic_chain #(
   parameter int IN_W  = 16,
   parameter int N     = 4,
   parameter int SEL_W = 2,
   parameter int L_MIN = 1,
   parameter int LAT_W = 16,
   parameter bit SAT   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic signed [IN_W-1:0] in_data,
   input  logic [SEL_W-1:0]       cut_sel,
   output logic                   out_valid,
   output logic signed [IN_W-1:0] out_data,
   output logic [LAT_W-1:0]       lat_o
);
   localparam int L_MAX = L_MIN + (2**SEL_W) - 1;
   localparam int LW    = $clog2(L_MAX + 1);
   localparam int DAW   = IN_W + N * L_MAX;
   localparam int IAW   = IN_W + (N - 1) * L_MAX + 1;

   generate
      if (N < 1 || N > 6) begin : g_bad_n
         $error("cutoff_cic_chain: N out of range");
      end
      if (L_MIN < 1) begin : g_bad_lmin
         $error("cutoff_cic_chain: L_MIN must be at least 1");
      end
      if (DAW > 64 || IN_W < 4) begin : g_bad_w
         $error("cutoff_cic_chain: width out of range");
      end
   endgenerate

   logic [LW-1:0]          log2r_q;
   logic [LW-1:0]          sel_l2;
   logic                   bound, clr;
   logic                   dec_stb, cmp_stb;
   logic signed [IN_W-1:0] dec_data, cmp_data;

   assign sel_l2 = LW'(cut_sel) + LW'(L_MIN);
   assign clr    = bound && (sel_l2 != log2r_q);
   assign lat_o  = LAT_W'(((N + 3) << log2r_q) + N);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log2r_q   <= LW'(L_MIN);
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (clr) log2r_q <= sel_l2;
      end
   end

   cic_decim #(.IN_W(IN_W), .N(N), .L_MAX(L_MAX), .LW(LW), .AW(DAW)) i_decim (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_data(in_data),
      .log2r(log2r_q), .bound(bound), .dec_stb(dec_stb), .dec_data(dec_data));

   cic_comp_fir #(.W(IN_W), .SAT(SAT)) i_comp (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_stb(dec_stb), .in_data(dec_data),
      .out_stb(cmp_stb), .out_data(cmp_data));

   cic_interp #(.IN_W(IN_W), .N(N), .LW(LW), .IW(IAW)) i_interp (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_stb(cmp_stb), .in_data(cmp_data),
      .tick(in_valid), .log2r(log2r_q), .out_data(out_data));

   // R3: the active ratio moves only on a boundary switch
   p_ratio_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(log2r_q) |-> $past(clr));
   // R1: output strobes pair with input strobes one cycle earlier
   p_out_pairs_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
   // R4: the switching sample leaves a zero output
   p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (out_data == '0));
endmodule

// File: tb/test_cutoff_cic_chain.sv
module test_cutoff_cic_chain;
   timeunit 1ns;
   timeprecision 1ps;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_data = '0;
   logic [1:0]         cut_sel = '0;
   logic               out_valid;
   logic signed [15:0] out_data;
   logic [15:0]        lat_o;

   int errors = 0;
   int checks = 0;
   logic signed [15:0] y;
   logic ov, ov_after;

   always #2.5 clk = ~clk;

   cutoff_cic_chain i_cutoff_cic_chain (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .cut_sel(cut_sel), .out_valid(out_valid), .out_data(out_data), .lat_o(lat_o));

   function automatic int exp_lat(input int s);
      return 7 * (1 << (s + 1)) + 4;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic do_reset();
      in_valid = 1'b0;
      cut_sel  = '0;
      rst_n    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic send(input int x);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 16'(x);
      @(negedge clk);
      in_valid = 1'b0;
      y  = out_data;
      ov = out_valid;
      @(negedge clk);
      ov_after = out_valid;
      @(negedge clk);
   endtask

   task automatic set_rate(input int s, input int fill);
      cut_sel = 2'(s);
      for (int i = 0; i < 40; i++) begin
         if (int'(lat_o) == exp_lat(s)) break;
         send(fill);
      end
      check(int'(lat_o) == exp_lat(s), "R2 latency status", int'(lat_o), exp_lat(s));
   endtask

   task automatic t_reset();
      do_reset();
      check(out_valid == 1'b0, "R7 out_valid after reset", int'(out_valid), 0);
      check(out_data == 16'sd0, "R7 out_data after reset", int'(out_data), 0);
      check(lat_o == 16'd18, "R7 lat_o after reset", int'(lat_o), 18);
   endtask

   task automatic t_strobe();
      send(123);
      check(ov == 1'b1, "R1 out_valid after in_valid", int'(ov), 1);
      check(ov_after == 1'b0, "R1 out_valid single cycle", int'(ov_after), 0);
   endtask

   task automatic t_defer();
      do_reset();
      cut_sel = 2'd2;
      send(0);
      check(lat_o == 16'd18, "R3 no switch mid-period", int'(lat_o), 18);
      send(0);
      check(lat_o == 16'd60, "R3 switch at boundary", int'(lat_o), 60);
      cut_sel = 2'd0;
      repeat (7) send(0);
      check(lat_o == 16'd60, "R3 held through R=8 period", int'(lat_o), 60);
      send(0);
      check(lat_o == 16'd18, "R3 switch after 8th sample", int'(lat_o), 18);
   endtask

   task automatic t_dc(input int s, input int x, input string req);
      int r = 1 << (s + 1);
      int bad = 0;
      int last = 0;
      set_rate(s, 0);
      repeat (24 * r + 40) send(x);
      for (int i = 0; i < 8; i++) begin
         send(x);
         if (int'(y) != x) begin bad++; last = int'(y); end
      end
      check(bad == 0, req, (bad == 0) ? x : last, x);
   endtask

   task automatic t_alt(input int s, input int a);
      int r = 1 << (s + 1);
      int bad = 0;
      int last = 0;
      set_rate(s, 0);
      for (int i = 0; i < 24 * r + 40; i++) send((i % 2 == 0) ? a : -a);
      for (int i = 0; i < 8; i++) begin
         send((i % 2 == 0) ? a : -a);
         if (y != 16'sd0) begin bad++; last = int'(y); end
      end
      check(bad == 0, "R6 alternating input rejected", last, 0);
   endtask

   task automatic t_clear();
      int bad = 0;
      int last = 0;
      set_rate(0, 0);
      repeat (100) send(1000);
      check(int'(y) == 1000, "R4 DC loaded before switch", int'(y), 1000);
      cut_sel = 2'd1;
      for (int i = 0; i < 4; i++) begin
         send(0);
         if (lat_o == 16'd32) break;
      end
      check(lat_o == 16'd32, "R4 switch reached", int'(lat_o), 32);
      check(y == 16'sd0, "R4 switching sample output", int'(y), 0);
      for (int i = 0; i < 40; i++) begin
         send(0);
         if (y != 16'sd0) begin bad++; last = int'(y); end
      end
      check(bad == 0, "R4 no residue after clear", last, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R1 watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_strobe();
      t_defer();
      t_dc(0, 1000, "R5 DC gain R=2");
      t_dc(1, -2345, "R5 DC gain R=4 negative");
      t_dc(2, 500, "R5 DC gain R=8");
      t_dc(3, 32767, "R8 full-scale positive R=16");
      t_dc(3, -32768, "R8 full-scale negative R=16");
      t_alt(1, 3000);
      t_alt(3, 20000);
      t_clear();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule